// File: doc/BRIEF.md
# Multicore Sleep and Inter-Core Interrupt Controller

This block handles the control side of sleeping, waking and interrupt entry for a group of cores that share one data memory. Each core can ask to sleep until an interrupt arrives. It can raise one of its own four interrupt lines from software, or send a wake-up interrupt to another core by core number. For each core the block returns a run/stall level, a one-cycle redirect strobe with the handler address, and a write of the continuation address into link register R31. A shared background timer is a fourth interrupt source.

A core that goes to sleep has its next PC written into R31 and stays stalled until an enabled interrupt is granted. It is then redirected to its handler, and the handler returns through R31. When a running core is interrupted, its next PC goes into R31 at the moment of redirect. A cross-core interrupt acts only on a sleeping target and is dropped otherwise. The handler address depends on both the core number and the interrupt line.

Top module: `mc_wake_ctrl`

## Requirements
- R1: After reset every core runs (`core_run` all 1), no redirect or link write is issued, and all interrupt enables are clear, so a software interrupt on any line produces no redirect.
- R2: A sleep request (`wfi_req`) from a running core gives, one cycle later, `link_we`=1 with `link_pc` equal to the supplied `wfi_pc`, and `core_run`=0. The core stays stalled until it is woken.
- R3: A granted interrupt on line L of core C produces `redir_vld`=1 and `redir_pc` = VEC_BASE + 4*C + L (VEC_BASE defaults to 1000) two cycles after the request cycle.
- R4: A cross-core interrupt aimed at a sleeping core with line 0 enabled wakes that core. The redirect goes to its line-0 handler, `core_run` returns to 1 in the same cycle, and no link write is made, because R31 already holds the continuation.
- R5: A cross-core interrupt aimed at a core that is not sleeping is dropped and never causes a redirect.
- R6: A cross-core interrupt whose target field (width $clog2(NC)+1) is NC or larger is ignored.
- R7: A software interrupt with line number n (2-bit `swi_num`) raises line n of the issuing core only.
- R8: When several enabled lines are pending on a core, the lowest-numbered line is granted first, and the others follow in later cycles.
- R9: A request on a line whose enable bit is clear is discarded, not held. Enabling the line later raises nothing, and a sleeping core stays asleep.
- R10: The timer advances on each cycle with `tick_en`=1, including while cores sleep. Every TMR_DEL-th tick raises line 3 on each core that has line 3 enabled.
- R11: When an interrupt is granted to a running core, the same cycle as the redirect carries `link_we`=1 with `link_pc` equal to that core's `pc_next`.
- R12: A sleeping core's own sleep, software-interrupt and cross-core send requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_en | input | 1 | One instruction step of the global timer |
| ien_wr | input | NC | Per-core enable write strobe |
| ien_val | input | NC*4 | Per-core new enable bits, bit L enables line L |
| wfi_req | input | NC | Per-core sleep request |
| wfi_pc | input | NC*PCW | Per-core next PC for the sleep request |
| swi_req | input | NC | Per-core local software interrupt strobe |
| swi_num | input | NC*2 | Per-core software interrupt line number |
| send_req | input | NC | Per-core cross-core interrupt strobe |
| send_tgt | input | NC*($clog2(NC)+1) | Per-core target core number |
| pc_next | input | NC*PCW | Per-core next PC of a running core |
| core_run | output | NC | 1 = core may execute, 0 = stalled |
| redir_vld | output | NC | One-cycle redirect strobe |
| redir_pc | output | NC*PCW | Handler address for the redirect |
| link_we | output | NC | R31 write strobe |
| link_pc | output | NC*PCW | Value written to R31 |

## Verification
The hardest situation to reach is two lines becoming pending on one core in the same cycle. A core can raise only one software line per cycle, so the bench counts timer ticks itself. It puts a core to sleep and fires a cross-core send in exactly the cycle the timer wraps, which latches lines 0 and 3 together. The bench then expects the line-0 wake with no link write, followed by a line-3 entry that writes `pc_next`, because by then the core is running. Dropped sends are checked the same way: a sleeping core with line 0 disabled must stay stalled and must not wake when the line is enabled later.

// File: rtl/mcw_pkg.sv
package mcw_pkg;
  localparam int NLINE     = 4;
  localparam int LW        = 2;
  localparam int LINE_SEND = 0;
  localparam int LINE_TMR  = 3;

  // handler address: per-core block of NLINE entries, one per line
  function automatic logic [31:0] vec_addr(input logic [31:0] base,
                                           input logic [31:0] core,
                                           input logic [31:0] line);
    return base + core * 32'(NLINE) + line;
  endfunction

  // lowest set bit index wins
  function automatic logic [LW-1:0] low_line(input logic [NLINE-1:0] m);
    logic [LW-1:0] r;
    r = '0;
    for (int i = NLINE - 1; i >= 0; i--) begin
      if (m[i]) r = LW'(i);
    end
    return r;
  endfunction

  function automatic logic [NLINE-1:0] line_dec(input logic [LW-1:0] n);
    logic [NLINE-1:0] r;
    r = '0;
    r[n] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/mcw_timer.sv
module mcw_timer #(
  parameter int TMR_DEL = 16,
  localparam int CW = (TMR_DEL > 1) ? $clog2(TMR_DEL) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic tmr_fire
);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap     = tick_en && (cnt_q == CW'(TMR_DEL - 1));
  assign tmr_fire = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CW'(TMR_DEL - 1)); // R10
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tick_en |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/mcw_send_route.sv
module mcw_send_route #(
  parameter int NC = 4,
  parameter int TW = 3
) (
  input  logic [NC-1:0]    send_req,
  input  logic [NC*TW-1:0] send_tgt,
  input  logic [NC-1:0]    asleep,
  output logic [NC-1:0]    send_hit
);
  always_comb begin
    for (int t = 0; t < NC; t++) begin
      send_hit[t] = 1'b0;
      for (int s = 0; s < NC; s++) begin
        // only running senders, only exact in-range targets
        if (send_req[s] && !asleep[s] && (send_tgt[s*TW +: TW] == TW'(t)))
          send_hit[t] = 1'b1;
      end
      send_hit[t] = send_hit[t] & asleep[t];
    end
  end
endmodule

// File: rtl/mcw_core_slot.sv
module mcw_core_slot #(
  parameter int CORE     = 0,
  parameter int PCW      = 32,
  parameter int VEC_BASE = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_wr,
  input  logic [mcw_pkg::NLINE-1:0] en_val,
  input  logic                     wfi_req,
  input  logic [PCW-1:0]           wfi_pc,
  input  logic                     swi_req,
  input  logic [mcw_pkg::LW-1:0]   swi_num,
  input  logic                     send_hit,
  input  logic                     tmr_fire,
  input  logic [PCW-1:0]           pc_next,
  output logic                     asleep,
  output logic                     run,
  output logic                     redir_vld,
  output logic [PCW-1:0]           redir_pc,
  output logic                     link_we,
  output logic [PCW-1:0]           link_pc
);
  import mcw_pkg::*;

  logic [NLINE-1:0] en_q, en_d, pend_q, pend_d, new_set, src_set, avail, grant_mask;
  logic             asleep_q, req_ok, grant_any, wfi_take;
  logic [LW-1:0]    grant_line;
  logic [PCW-1:0]   vec_pc;

  // named internal events
  assign req_ok     = !asleep_q;
  assign avail      = pend_q & en_q;
  assign grant_any  = |avail;
  assign grant_line = low_line(avail);
  assign grant_mask = grant_any ? line_dec(grant_line) : '0;
  assign wfi_take   = wfi_req && req_ok && !grant_any;
  assign vec_pc     = PCW'(vec_addr(32'(VEC_BASE), 32'(CORE), 32'(grant_line)));

  always_comb begin
    src_set = '0;
    if (swi_req && req_ok) src_set = src_set | line_dec(swi_num);
    src_set[LINE_SEND] = src_set[LINE_SEND] | send_hit;
    src_set[LINE_TMR]  = src_set[LINE_TMR]  | tmr_fire;
  end

  assign new_set = src_set & en_q;
  assign en_d    = en_wr ? en_val : en_q;
  assign pend_d  = ((pend_q & ~grant_mask) | new_set) & en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      pend_q    <= '0;
      asleep_q  <= 1'b0;
      redir_vld <= 1'b0;
      redir_pc  <= '0;
      link_we   <= 1'b0;
      link_pc   <= '0;
    end else begin
      en_q      <= en_d;
      pend_q    <= pend_d;
      asleep_q  <= grant_any ? 1'b0 : (wfi_take ? 1'b1 : asleep_q);
      redir_vld <= grant_any;
      redir_pc  <= vec_pc;
      link_we   <= wfi_take || (grant_any && !asleep_q);
      link_pc   <= wfi_take ? wfi_pc : pc_next;
    end
  end

  assign asleep = asleep_q;
  assign run    = !asleep_q;

  AST_WFI_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    wfi_take |=> link_we && (link_pc == $past(wfi_pc)) && !run); // R2
  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_q && !grant_any |=> !run); // R2
  AST_WAKE_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_q && grant_any |=> run && redir_vld && !link_we); // R4
  AST_SEND_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    send_hit |-> asleep_q); // R5
  AST_DIS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[LINE_SEND] && !en_wr |=> !pend_q[LINE_SEND]); // R9
  AST_REST_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    grant_any && ($countones(avail) > 1) && !en_wr |=> (|pend_q)); // R8
  AST_RUNNING_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    grant_any && !asleep_q |=> link_we && (link_pc == $past(pc_next))); // R11
endmodule

// File: rtl/mc_wake_ctrl.sv
module mc_wake_ctrl #(
  parameter int NC       = 4,
  parameter int PCW      = 32,
  parameter int VEC_BASE = 1000,
  parameter int TMR_DEL  = 16,
  localparam int TW = $clog2(NC) + 1,
  localparam int NL = mcw_pkg::NLINE,
  localparam int LW = mcw_pkg::LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [NC-1:0]     ien_wr,
  input  logic [NC*NL-1:0]  ien_val,
  input  logic [NC-1:0]     wfi_req,
  input  logic [NC*PCW-1:0] wfi_pc,
  input  logic [NC-1:0]     swi_req,
  input  logic [NC*LW-1:0]  swi_num,
  input  logic [NC-1:0]     send_req,
  input  logic [NC*TW-1:0]  send_tgt,
  input  logic [NC*PCW-1:0] pc_next,
  output logic [NC-1:0]     core_run,
  output logic [NC-1:0]     redir_vld,
  output logic [NC*PCW-1:0] redir_pc,
  output logic [NC-1:0]     link_we,
  output logic [NC*PCW-1:0] link_pc
);
  logic          tmr_fire;
  logic [NC-1:0] asleep, send_hit;

  mcw_timer #(.TMR_DEL(TMR_DEL)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tmr_fire(tmr_fire)
  );

  mcw_send_route #(.NC(NC), .TW(TW)) u_route (
    .send_req(send_req), .send_tgt(send_tgt), .asleep(asleep), .send_hit(send_hit)
  );

  for (genvar c = 0; c < NC; c++) begin : g_core
    mcw_core_slot #(.CORE(c), .PCW(PCW), .VEC_BASE(VEC_BASE)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr    (ien_wr[c]),
      .en_val   (ien_val[c*NL +: NL]),
      .wfi_req  (wfi_req[c]),
      .wfi_pc   (wfi_pc[c*PCW +: PCW]),
      .swi_req  (swi_req[c]),
      .swi_num  (swi_num[c*LW +: LW]),
      .send_hit (send_hit[c]),
      .tmr_fire (tmr_fire),
      .pc_next  (pc_next[c*PCW +: PCW]),
      .asleep   (asleep[c]),
      .run      (core_run[c]),
      .redir_vld(redir_vld[c]),
      .redir_pc (redir_pc[c*PCW +: PCW]),
      .link_we  (link_we[c]),
      .link_pc  (link_pc[c*PCW +: PCW])
    );
  end

  AST_RUN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    core_run == ~asleep); // R2
endmodule

// File: tb/mc_wake_ctrl_tb_top.sv
module mc_wake_ctrl_tb_top;
  localparam int NC = 4, PCW = 32, TW = 3, DEL = 16, VB = 1000;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic [NC-1:0] ien_wr = '0, wfi_req = '0, swi_req = '0, send_req = '0;
  logic [NC*4-1:0] ien_val = '0;
  logic [NC*PCW-1:0] wfi_pc = '0, pc_next;
  logic [NC*2-1:0] swi_num = '0;
  logic [NC*TW-1:0] send_tgt = '0;
  logic [NC-1:0] core_run, redir_vld, link_we;
  logic [NC*PCW-1:0] redir_pc, link_pc;
  logic [NC-1:0] seen;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  for (genvar c = 0; c < NC; c++) begin : g_pc
    assign pc_next[c*PCW +: PCW] = 32'h100 + c;
  end

  mc_wake_ctrl #(.NC(NC), .PCW(PCW), .VEC_BASE(VB), .TMR_DEL(DEL)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ien_wr(ien_wr), .ien_val(ien_val),
    .wfi_req(wfi_req), .wfi_pc(wfi_pc), .swi_req(swi_req), .swi_num(swi_num),
    .send_req(send_req), .send_tgt(send_tgt), .pc_next(pc_next), .core_run(core_run),
    .redir_vld(redir_vld), .redir_pc(redir_pc), .link_we(link_we), .link_pc(link_pc));

  // {core, line, enable mask, expect redirect}
  localparam logic [8:0] VT [7] = '{
    {2'd0, 2'd2, 4'b1111, 1'b1},
    {2'd1, 2'd0, 4'b0001, 1'b1},
    {2'd2, 2'd3, 4'b1000, 1'b1},
    {2'd3, 2'd1, 4'b1101, 1'b0},
    {2'd3, 2'd1, 4'b0010, 1'b1},
    {2'd1, 2'd3, 4'b0111, 1'b0},
    {2'd2, 2'd1, 4'b1111, 1'b1}
  };

  function automatic logic [31:0] exp_vec(input int c, input int l);
    return 32'(VB + 4 * c + l);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    seen = seen | redir_vld;
  endtask

  task automatic set_en(input int c, input logic [3:0] m);
    ien_wr[c] = 1'b1; ien_val[c*4 +: 4] = m;
    step();
    ien_wr[c] = 1'b0;
  endtask

  task automatic do_wfi(input int c, input logic [31:0] pc);
    wfi_req[c] = 1'b1; wfi_pc[c*PCW +: PCW] = pc;
    step();
    wfi_req[c] = 1'b0;
    chk(link_we[c] && link_pc[c*PCW +: PCW] == pc, "R2 link", link_pc[c*PCW +: PCW], pc);
    chk(core_run[c] == 1'b0, "R2 stall", core_run[c], 0);
  endtask

  task automatic send(input int s, input logic [TW-1:0] t);
    send_req[s] = 1'b1; send_tgt[s*TW +: TW] = t;
    step();
    send_req[s] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    seen = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(core_run == '1, "R1 run", core_run, 4'hF);
    chk(redir_vld == '0 && link_we == '0, "R1 strobes", {redir_vld, link_we}, 0);
    swi_req[0] = 1'b1; swi_num[1:0] = 2'd0;
    step(); swi_req[0] = 1'b0;
    step(); step();
    chk(seen == '0, "R1 enables clear", seen, 0);

    // table walk: R3, R7, R9, R11
    for (int i = 0; i < 7; i++) begin
      int c, l;
      c = int'(VT[i][8:7]); l = int'(VT[i][6:5]);
      set_en(c, VT[i][4:1]);
      seen = '0;
      swi_req[c] = 1'b1; swi_num[c*2 +: 2] = VT[i][6:5];
      step(); swi_req[c] = 1'b0;
      step();
      if (VT[i][0]) begin
        chk(redir_vld[c] && redir_pc[c*PCW +: PCW] == exp_vec(c, l), "R3 vector",
            redir_pc[c*PCW +: PCW], exp_vec(c, l));
        chk(link_we[c] && link_pc[c*PCW +: PCW] == 32'h100 + c, "R11 link",
            link_pc[c*PCW +: PCW], 32'h100 + c);
      end
      step();
      chk((seen & ~(4'(VT[i][0]) << c)) == '0, "R7 R9 only issuer", seen, 4'(VT[i][0]) << c);
      set_en(c, 4'b0000);
    end

    // R2 stall held; R5 send to awake core dropped
    set_en(2, 4'b0001);
    seen = '0;
    send(0, 3'd2); step(); step();
    chk(seen == '0 && core_run[2], "R5 awake target", seen, 0);
    do_wfi(2, 32'h222);
    step(); step();
    chk(core_run[2] == 1'b0, "R2 held", core_run[2], 0);
    // R6 out of range targets
    seen = '0;
    send(0, 3'd4); send(1, 3'd6); step(); step();
    chk(seen == '0 && !core_run[2], "R6 range", seen, 0);
    // R4 wake
    send(0, 3'd2);
    step();
    chk(redir_vld[2] && redir_pc[2*PCW +: PCW] == exp_vec(2, 0), "R4 vector",
        redir_pc[2*PCW +: PCW], exp_vec(2, 0));
    chk(core_run[2] && !link_we[2], "R4 run no link", {core_run[2], link_we[2]}, 2);
    set_en(2, 4'b0000);

    // R9 disabled line on sleeping core, then later enable
    do_wfi(3, 32'h333);
    seen = '0;
    send(0, 3'd3); step();
    set_en(3, 4'b0001); step(); step();
    chk(seen == '0 && !core_run[3], "R9 dropped", seen, 0);
    send(0, 3'd3); step();
    chk(core_run[3] && redir_pc[3*PCW +: PCW] == exp_vec(3, 0), "R9 R4 later wake",
        redir_pc[3*PCW +: PCW], exp_vec(3, 0));
    set_en(3, 4'b0000);

    // R12 requests from a sleeping core
    set_en(0, 4'b0101);
    set_en(3, 4'b0001);
    do_wfi(3, 32'h334);
    do_wfi(0, 32'h300);
    seen = '0;
    swi_req[0] = 1'b1; swi_num[1:0] = 2'd2;
    step(); swi_req[0] = 1'b0;
    send(0, 3'd3);
    wfi_req[0] = 1'b1; wfi_pc[PCW-1:0] = 32'h777;
    step(); wfi_req[0] = 1'b0;
    chk(!link_we[0], "R12 sleep req ignored", link_we[0], 0);
    step();
    chk(seen == '0 && core_run[0] == 0 && core_run[3] == 0, "R12 ignored", seen, 0);
    send(1, 3'd0); step();
    chk(redir_vld[0] && core_run[0], "R12 R4 wake core0", redir_vld[0], 1);
    send(1, 3'd3); step();
    chk(redir_vld[3] && core_run[3], "R12 R4 wake core3", redir_vld[3], 1);
    set_en(0, 4'b0000); set_en(3, 4'b0000);

    // R10 timer: core2 asleep, core1 awake, both line 3
    set_en(1, 4'b1000);
    set_en(2, 4'b1000);
    do_wfi(2, 32'h444);
    seen = '0;
    tick_en = 1'b1;
    for (int k = 0; k < DEL - 1; k++) step();
    step();
    tick_en = 1'b0;
    chk(seen == '0, "R10 not early", seen, 0);
    step();
    chk(redir_vld[2] && redir_pc[2*PCW +: PCW] == exp_vec(2, 3) && core_run[2], "R10 sleeper",
        redir_pc[2*PCW +: PCW], exp_vec(2, 3));
    chk(redir_vld[1] && redir_pc[PCW +: PCW] == exp_vec(1, 3), "R10 all cores",
        redir_pc[PCW +: PCW], exp_vec(1, 3));
    chk(!redir_vld[0] && !redir_vld[3], "R10 disabled cores", redir_vld, 6);
    set_en(1, 4'b0000); set_en(2, 4'b0000);

    // R8 lines 0 and 3 pending together
    set_en(1, 4'b1001);
    do_wfi(1, 32'h555);
    tick_en = 1'b1;
    for (int k = 0; k < DEL - 1; k++) step();
    send_req[0] = 1'b1; send_tgt[2:0] = 3'd1;
    step();
    tick_en = 1'b0; send_req[0] = 1'b0;
    step();
    chk(redir_vld[1] && redir_pc[PCW +: PCW] == exp_vec(1, 0), "R8 low first",
        redir_pc[PCW +: PCW], exp_vec(1, 0));
    chk(!link_we[1] && core_run[1], "R8 R4 wake no link", link_we[1], 0);
    step();
    chk(redir_vld[1] && redir_pc[PCW +: PCW] == exp_vec(1, 3), "R8 second",
        redir_pc[PCW +: PCW], exp_vec(1, 3));
    chk(link_we[1] && link_pc[PCW +: PCW] == 32'h101, "R8 R11 link", link_pc[PCW +: PCW], 32'h101);
    step();
    chk(!redir_vld[1], "R8 drained", redir_vld[1], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule